// File: doc/BRIEF.md
# Bus Tenure Watchdog Unit

This unit sits beside an arbitrated system bus and runs three independent watchdog counters over it. One times the address phase, from the moment a master accepts its grant until the address is acknowledged. One times the data phase, from its start until it is terminated. One times general bus idleness. When the address phase overruns, the unit acknowledges the address on the slave's behalf. It then ends the data phase that follows with a transfer-error acknowledge. When the data phase overruns, the unit drives the transfer-error acknowledge directly. Idleness only raises a status flag.

Each watchdog has its own enable and a 28-bit programmed limit. The effective 32-bit limit is that field with four low bits that are always one. Every expiry sets its own sticky status bit, which software clears by writing a one to it. A single interrupt line reports any status bit whose mask bit is set. The register port is a plain single-cycle write strobe with a combinational read. Every event input is a one-cycle level sampled at the rising clock edge, so the unit has no streaming interface and no back-pressure.

Top module: `bus_wdog_unit`

## Requirements
- R1: After reset, status, interrupt mask and control all read zero, both acknowledge outputs and the interrupt are low, and every limit field reads back the reset field value (default 0x10).
- R2: The register map uses `reg_addr` word indices. Index 0 is control: bit0 enables the address watchdog, bit1 the data watchdog, bit2 the idle watchdog. Index 1 is status and index 2 is the mask, both using bit0 for address, bit1 for data and bit2 for idle. Indices 3, 4 and 5 hold the address, data and idle limit fields in bits 31:4. A limit reads back with bits 3:0 as zero, and any other index reads zero. The effective limit L is {field, 4'hF}.
- R3: An edge with `gnt_accept` high starts the address counter. If `addr_ack` is not seen at any of the next L+1 edges, `force_aack` is high for exactly one cycle, in the cycle after the (L+1)th edge, and status bit0 is set one edge later.
- R4: An `addr_ack` seen at or before the (L+1)th edge after the start stops the address counter, and no `force_aack` follows.
- R5: After an address time-out, the next edge with `data_start` high produces a one-cycle `force_tea` in the following cycle. This also stops the data counter.
- R6: An edge with `data_start` high starts the data counter. If `data_end` is not seen at any of the next L+1 edges, `force_tea` pulses for one cycle and status bit1 is set one edge later.
- R7: After L+1 consecutive edges with `bus_active` low, the idle watchdog sets status bit2. It drives neither acknowledge, and then it restarts counting from zero.
- R8: With the data enable set, the address watchdog runs even when the address enable bit is zero.
- R9: A watchdog whose enable is off does not count, fire or set status.
- R10: Status bits stay set until a write to index 1 with a one in that bit position. A new expiry at the same edge as the clearing write wins.
- R11: `irq` is high exactly when some status bit and the mask bit at the same position are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt_accept | input | 1 | A master accepted its bus grant this cycle |
| addr_ack | input | 1 | Address phase acknowledged by a slave |
| data_start | input | 1 | A data phase begins this cycle |
| data_end | input | 1 | The data phase is terminated this cycle |
| bus_active | input | 1 | Any bus activity this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| force_aack | output | 1 | Forced address acknowledge pulse |
| force_tea | output | 1 | Transfer-error acknowledge pulse |
| status | output | 3 | Sticky time-out flags: idle, data, address |
| irq | output | 1 | Masked interrupt |

## Verification
The bench places acknowledges right at the boundary of the limit. A counter that compares against the bare 28-bit field, or that is off by one edge, fires early, late, or when it should not. It follows an address time-out with a data start and checks that exactly one error acknowledge appears. A unit that forgot the pending error, or kept it after use, gives no pulse or a spurious second one. It runs with only the data enable set, where a design that ignores the implied address enable never forces an acknowledge. It also issues clearing writes and reprograms limits at random against a cycle model. This exposes a clear that beats a simultaneous expiry, status that is not sticky, and an interrupt that ignores the mask.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NUM_WD  = 3;
  localparam int WD_ADDR = 0;
  localparam int WD_DATA = 1;
  localparam int WD_IDLE = 2;

  typedef enum logic [2:0] {
    RI_CTRL  = 3'd0,
    RI_STAT  = 3'd1,
    RI_MASK  = 3'd2,
    RI_LIM_A = 3'd3,
    RI_LIM_D = 3'd4,
    RI_LIM_I = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W    = 32,
  parameter bit FREE_RUN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  generate
    if (FREE_RUN) begin : g_free
      // restarts at once after activity or after an expiry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          fire_o <= 1'b0;
        end else begin
          fire_o <= 1'b0;
          if (!en_i || stop_i) begin
            cnt_q <= '0;
          end else if (cnt_q >= limit_i) begin
            fire_o <= 1'b1;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end else begin : g_tenure
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q  <= 1'b0;
          cnt_q  <= '0;
          fire_o <= 1'b0;
        end else begin
          fire_o <= 1'b0;
          if (!en_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
          end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
          end else if (run_q && stop_i) begin
            run_q <= 1'b0;
          end else if (run_q) begin
            if (cnt_q >= limit_i) begin
              fire_o <= 1'b1;
              run_q  <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int                 FIELD_W   = 28,
  parameter int                 DATA_W    = 32,
  parameter logic [FIELD_W-1:0] RST_FIELD = 28'h10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_i,
  input  logic [2:0]                      addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [NUM_WD-1:0]               set_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_WD-1:0]               ctrl_o,
  output logic [NUM_WD-1:0]               mask_o,
  output logic [NUM_WD-1:0]               stat_o,
  output logic [NUM_WD-1:0][FIELD_W-1:0]  lim_o
);
  localparam int LOW_W = DATA_W - FIELD_W;

  logic [NUM_WD-1:0] clr;
  logic              unused_low;

  assign unused_low = ^wdata_i[LOW_W-1:0];
  assign clr = (wr_i && addr_i == RI_STAT) ? wdata_i[NUM_WD-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      mask_o <= '0;
      stat_o <= '0;
    end else begin
      stat_o <= (stat_o & ~clr) | set_i;
      if (wr_i && addr_i == RI_CTRL) ctrl_o <= wdata_i[NUM_WD-1:0];
      if (wr_i && addr_i == RI_MASK) mask_o <= wdata_i[NUM_WD-1:0];
    end
  end

  generate
    for (genvar i = 0; i < NUM_WD; i++) begin : g_lim
      localparam logic [2:0] IDX = 3'(int'(RI_LIM_A) + i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      lim_o[i] <= RST_FIELD;
        else if (wr_i && addr_i == IDX)  lim_o[i] <= wdata_i[DATA_W-1:LOW_W];
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RI_CTRL:  rdata_o[NUM_WD-1:0] = ctrl_o;
      RI_STAT:  rdata_o[NUM_WD-1:0] = stat_o;
      RI_MASK:  rdata_o[NUM_WD-1:0] = mask_o;
      RI_LIM_A: rdata_o = {lim_o[WD_ADDR], {LOW_W{1'b0}}};
      RI_LIM_D: rdata_o = {lim_o[WD_DATA], {LOW_W{1'b0}}};
      RI_LIM_I: rdata_o = {lim_o[WD_IDLE], {LOW_W{1'b0}}};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_wdog_unit.sv
module bus_wdog_unit
  import wdog_pkg::*;
#(
  parameter int                 CNT_W     = 32,
  parameter int                 FIELD_W   = 28,
  parameter logic [FIELD_W-1:0] RST_FIELD = 28'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_accept,
  input  logic              addr_ack,
  input  logic              data_start,
  input  logic              data_end,
  input  logic              bus_active,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              force_aack,
  output logic              force_tea,
  output logic [NUM_WD-1:0] status,
  output logic              irq
);
  localparam int LOW_W = CNT_W - FIELD_W;

  logic [NUM_WD-1:0]              ctrl_q;
  logic [NUM_WD-1:0]              mask_q;
  logic [NUM_WD-1:0][FIELD_W-1:0] lim_field;
  logic [NUM_WD-1:0]              wd_en, wd_start, wd_stop, wd_fire;
  logic [NUM_WD-1:0][CNT_W-1:0]   wd_limit;
  logic                           err_pend_q;
  logic                           tea_pend_q;

  wdog_regs #(
    .FIELD_W   (FIELD_W),
    .DATA_W    (CNT_W),
    .RST_FIELD (RST_FIELD)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .set_i   (wd_fire),
    .rdata_o (reg_rdata),
    .ctrl_o  (ctrl_q),
    .mask_o  (mask_q),
    .stat_o  (status),
    .lim_o   (lim_field)
  );

  // data enable implies the address watchdog
  assign wd_en[WD_ADDR]    = ctrl_q[WD_ADDR] | ctrl_q[WD_DATA];
  assign wd_en[WD_DATA]    = ctrl_q[WD_DATA];
  assign wd_en[WD_IDLE]    = ctrl_q[WD_IDLE];
  assign wd_start[WD_ADDR] = gnt_accept;
  assign wd_start[WD_DATA] = data_start;
  assign wd_start[WD_IDLE] = 1'b0;
  assign wd_stop[WD_ADDR]  = addr_ack;
  assign wd_stop[WD_DATA]  = data_end | tea_pend_q;
  assign wd_stop[WD_IDLE]  = bus_active;

  generate
    for (genvar i = 0; i < NUM_WD; i++) begin : g_wd
      assign wd_limit[i] = {lim_field[i], {LOW_W{1'b1}}};
      wdog_counter #(
        .CNT_W    (CNT_W),
        .FREE_RUN (i == WD_IDLE)
      ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (wd_en[i]),
        .start_i (wd_start[i]),
        .stop_i  (wd_stop[i]),
        .limit_i (wd_limit[i]),
        .fire_o  (wd_fire[i])
      );
    end
  endgenerate

  // an address time-out owes an error on the next data phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pend_q <= 1'b0;
      tea_pend_q <= 1'b0;
    end else begin
      tea_pend_q <= data_start & err_pend_q;
      if (!wd_en[WD_ADDR]) err_pend_q <= 1'b0;
      else                 err_pend_q <= wd_fire[WD_ADDR] | (err_pend_q & ~data_start);
    end
  end

  assign force_aack = wd_fire[WD_ADDR];
  assign force_tea  = wd_fire[WD_DATA] | tea_pend_q;
  assign irq        = |(status & mask_q);
endmodule

// File: rtl/bus_wdog_chk.sv
module bus_wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic       force_aack,
  input logic       force_tea,
  input logic [2:0] status,
  input logic       irq,
  input logic [2:0] ctrl
);
  // R3
  aack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_aack |=> !force_aack);

  // R3
  aack_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_aack |=> status[0]);

  // R10
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd1) |=> ((status & $past(status)) == $past(status)));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 3'b000));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 3'b000 && $past(ctrl) == 3'b000 && $past(ctrl, 2) == 3'b000)
      |-> (!force_aack && !force_tea));
endmodule

bind bus_wdog_unit bus_wdog_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .force_aack (force_aack),
  .force_tea  (force_tea),
  .status     (status),
  .irq        (irq),
  .ctrl       (ctrl_q)
);

// File: tb/bus_wdog_unit_tb.sv
module bus_wdog_unit_tb;
  localparam logic [27:0] RST_FIELD = 28'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gnt_accept = 0, addr_ack = 0, data_start = 0, data_end = 0, bus_active = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        force_aack, force_tea, irq;
  logic [2:0]  status;

  int checks = 0, fails = 0;
  int n_aack = 0, n_tea = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_wdog_unit u_dut (
    .clk(clk), .rst_n(rst_n), .gnt_accept(gnt_accept), .addr_ack(addr_ack),
    .data_start(data_start), .data_end(data_end), .bus_active(bus_active),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .force_aack(force_aack), .force_tea(force_tea),
    .status(status), .irq(irq)
  );

  // cycle model of the requirements
  logic [2:0]  m_ctrl, m_mask, m_stat;
  logic [27:0] m_lim [3];
  logic        a_run, d_run, m_af, m_df, m_if, m_pend, m_tp;
  logic [31:0] a_cnt, d_cnt, i_cnt;

  function automatic logic [31:0] lim_of(input logic [27:0] f);
    return {f, 4'hF};
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {29'd0, m_ctrl};
      3'd1: return {29'd0, m_stat};
      3'd2: return {29'd0, m_mask};
      3'd3: return {m_lim[0], 4'h0};
      3'd4: return {m_lim[1], 4'h0};
      3'd5: return {m_lim[2], 4'h0};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_mask = 0; m_stat = 0;
      for (int i = 0; i < 3; i++) m_lim[i] = RST_FIELD;
      a_run = 0; d_run = 0; m_af = 0; m_df = 0; m_if = 0; m_pend = 0; m_tp = 0;
      a_cnt = 0; d_cnt = 0; i_cnt = 0;
    end else begin
      logic oaf, odf, oif, otp, opend, aen;
      logic [2:0] clr;
      oaf = m_af; odf = m_df; oif = m_if; otp = m_tp; opend = m_pend;
      aen = m_ctrl[0] | m_ctrl[1];
      clr = (reg_wr && reg_addr == 3'd1) ? reg_wdata[2:0] : 3'd0;
      m_stat = (m_stat & ~clr) | {oif, odf, oaf};
      m_af = 0;
      if (!aen) begin a_run = 0; a_cnt = 0; end
      else if (gnt_accept) begin a_run = 1; a_cnt = 0; end
      else if (a_run && addr_ack) a_run = 0;
      else if (a_run) begin
        if (a_cnt >= lim_of(m_lim[0])) begin m_af = 1; a_run = 0; end
        else a_cnt++;
      end
      m_df = 0;
      if (!m_ctrl[1]) begin d_run = 0; d_cnt = 0; end
      else if (data_start) begin d_run = 1; d_cnt = 0; end
      else if (d_run && (data_end || otp)) d_run = 0;
      else if (d_run) begin
        if (d_cnt >= lim_of(m_lim[1])) begin m_df = 1; d_run = 0; end
        else d_cnt++;
      end
      m_if = 0;
      if (!m_ctrl[2] || bus_active) i_cnt = 0;
      else if (i_cnt >= lim_of(m_lim[2])) begin m_if = 1; i_cnt = 0; end
      else i_cnt++;
      m_tp = data_start & opend;
      m_pend = aen ? (oaf | (opend & ~data_start)) : 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_ctrl = reg_wdata[2:0];
          3'd2: m_mask = reg_wdata[2:0];
          3'd3: m_lim[0] = reg_wdata[31:4];
          3'd4: m_lim[1] = reg_wdata[31:4];
          3'd5: m_lim[2] = reg_wdata[31:4];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(force_aack === m_af, "R3 force_aack", {31'd0, force_aack}, {31'd0, m_af});
    chk(force_tea === (m_df | m_tp), "R6 force_tea", {31'd0, force_tea}, {31'd0, m_df | m_tp});
    chk(status === m_stat, "R10 status", {29'd0, status}, {29'd0, m_stat});
    chk(irq === |(m_stat & m_mask), "R11 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    chk(reg_rdata === model_read(reg_addr), "R2 readback", reg_rdata, model_read(reg_addr));
    if (force_aack) n_aack++;
    if (force_tea) n_tea++;
  endtask

  task automatic cyc(input bit g, aa, ds, de, act, wr, input logic [2:0] ad, input logic [31:0] wd);
    @(negedge clk);
    compare();
    gnt_accept = g; addr_ack = aa; data_start = ds; data_end = de; bus_active = act;
    reg_wr = wr; reg_addr = ad; reg_wdata = wd;
  endtask

  task automatic idle(input int n, input bit act);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, act, 0, 3'd1, 0);
  endtask

  task automatic wreg(input logic [2:0] ad, input logic [31:0] wd);
    cyc(0, 0, 0, 0, 1, 1, ad, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    reg_addr = 3'd3;
    #1;
    // R1 reset state
    chk(status == 0 && irq == 0 && !force_aack && !force_tea, "R1 reset outputs",
        {27'd0, status, irq, force_aack}, 0);
    chk(reg_rdata == {RST_FIELD, 4'h0}, "R1 limit reset", reg_rdata, {RST_FIELD, 4'h0});

    // R8: data enable alone runs the address watchdog; R5 error on next data phase
    wreg(3'd0, 32'h2); wreg(3'd3, 32'h10); wreg(3'd4, 32'h30); wreg(3'd2, 32'h7);
    wreg(3'd5, 32'h40);
    n_aack = 0; n_tea = 0;
    cyc(1, 0, 0, 0, 1, 0, 3'd1, 0);
    idle(40, 1);
    chk(n_aack == 1, "R8 implied address watchdog", n_aack, 1);
    chk(status[0] == 1'b1, "R3 address status", {29'd0, status}, 32'h1);
    cyc(0, 0, 1, 0, 1, 0, 3'd1, 0);
    idle(3, 1);
    chk(n_tea == 1, "R5 error after address time-out", n_tea, 1);
    idle(70, 1);
    chk(n_tea == 1, "R5 data counter stopped by error", n_tea, 1);

    // R4: acknowledge inside the window
    wreg(3'd0, 32'h1); wreg(3'd1, 32'h7);
    n_aack = 0;
    cyc(1, 0, 0, 0, 1, 0, 3'd1, 0);
    idle(20, 1);
    cyc(0, 1, 0, 0, 1, 0, 3'd1, 0);
    idle(40, 1);
    chk(n_aack == 0, "R4 acknowledged in time", n_aack, 0);

    // R9: all disabled
    wreg(3'd0, 32'h0); wreg(3'd1, 32'h7);
    n_aack = 0; n_tea = 0;
    cyc(1, 0, 1, 0, 0, 0, 3'd1, 0);
    idle(80, 0);
    chk(n_aack == 0 && n_tea == 0 && status == 0, "R9 disabled quiet",
        {n_aack[15:0], n_tea[12:0], status}, 0);

    // R7: idle watchdog flags only
    wreg(3'd0, 32'h4); wreg(3'd5, 32'h10);
    n_aack = 0; n_tea = 0;
    idle(40, 0);
    chk(status[2] == 1'b1, "R7 idle status", {29'd0, status}, 32'h4);
    chk(n_aack == 0 && n_tea == 0, "R7 no acknowledges", n_aack + n_tea, 0);
    chk(irq == 1'b1, "R11 masked irq on", {31'd0, irq}, 1);
    wreg(3'd2, 32'h0);
    cyc(0, 0, 0, 0, 1, 0, 3'd1, 0); #1;
    chk(irq == 1'b0, "R11 masked irq off", {31'd0, irq}, 0);
    chk(status[2] == 1'b1, "R10 sticky while masked", {29'd0, status}, 32'h4);
    wreg(3'd1, 32'h4);
    cyc(0, 0, 0, 0, 1, 0, 3'd1, 0); #1;
    chk(status[2] == 1'b0, "R10 write one clears", {29'd0, status}, 0);

    // R6: data watchdog time-out
    wreg(3'd0, 32'h2); wreg(3'd1, 32'h7);
    n_tea = 0;
    cyc(0, 0, 1, 0, 1, 0, 3'd1, 0);
    idle(70, 1);
    chk(n_tea == 1 && status[1] == 1'b1, "R6 data time-out",
        {n_tea[15:0], 13'd0, status}, {16'd1, 16'h2});

    // random traffic against the model
    for (int i = 0; i < 8000; i++) begin
      bit w;
      logic [2:0] a;
      logic [31:0] d;
      w = ($urandom_range(0, 99) < 2);
      a = 3'($urandom_range(0, 7));
      d = $urandom();
      if (w && a >= 3'd3 && a <= 3'd5) d = {26'd0, 2'($urandom_range(1, 3)), 4'($urandom())};
      cyc($urandom_range(0, 99) < 3, $urandom_range(0, 99) < 2,
          $urandom_range(0, 99) < 3, $urandom_range(0, 99) < 2,
          $urandom_range(0, 99) < 4, w, a, d);
    end
    @(negedge clk); compare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule